// File: doc/BRIEF.md
# Load/Store Data Lane Aligner

This block sits between a 64-bit core datapath and a 64-bit data memory port and handles the byte-lane steering for memory accesses. On the store side it takes the register value to be written, a two-bit access size and the three low address bits. It produces the write word with the data moved into the addressed byte lanes, and a matching byte-enable mask. On the load side it takes the 64-bit word read from memory, the same size and offset, and a flag that selects zero extension. It returns the addressed field, sign- or zero-extended to 64 bits, ready for the destination register.

The size code is 0 for a byte, 1 for a halfword, 2 for a word and 3 for a doubleword, so an access covers 2^size bytes. An access whose offset is not a multiple of its byte count is flagged as misaligned. Such an access enables no bytes and returns zeros, so that the core can raise its exception without any memory side effect. All outputs are registered and appear one clock after the inputs are sampled.

Top module: `lsu_lane_unit`

## Requirements
- R1: While rst_n is low, and in the first cycle after it, every output is zero regardless of the inputs.
- R2: For an aligned access, wr_be_o has exactly 2^size_i contiguous bits set, starting at bit addr_lo_i; bit j of the mask enables bits 8j+7..8j of wr_data_o.
- R3: For an aligned access, byte lane addr_lo_i+k of wr_data_o holds byte k of store_data_i for k < 2^size_i, and every lane that is not enabled is zero.
- R4: A doubleword load (size 3, offset 0) returns read_word_i unchanged, and load_unsigned_i has no effect on it.
- R5: A word load (size 2) returns the 32-bit field at the offset, sign-extended when load_unsigned_i is 0 and zero-extended when it is 1.
- R6: A halfword load (size 1) returns the 16-bit field at the offset, sign-extended when load_unsigned_i is 0 and zero-extended when it is 1.
- R7: A byte load (size 0) returns the byte at the offset, sign-extended when load_unsigned_i is 0 and zero-extended when it is 1.
- R8: misaligned_o is 1 exactly when addr_lo_i is not a multiple of 2^size_i.
- R9: For a misaligned access, wr_be_o, wr_data_o and load_value_o are all zero.
- R10: Outputs reflect the inputs sampled at the previous rising clock edge and do not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_size_i | input | 2 | Access size code: 0 byte, 1 half, 2 word, 3 double |
| load_unsigned_i | input | 1 | 1 selects zero extension for loads |
| addr_lo_i | input | 3 | Byte offset of the access within the 64-bit word |
| store_data_i | input | 64 | Register value to be stored |
| read_word_i | input | 64 | Word read from memory |
| wr_data_o | output | 64 | Lane-steered store data |
| wr_be_o | output | 8 | Byte enables for the store |
| load_value_o | output | 64 | Extracted and extended load result |
| misaligned_o | output | 1 | Access offset not a multiple of the access size |

## Verification
The assertions assume that reset is released synchronously and that the inputs are stable around the rising edge. They also assume that the size code and the offset refer to one access, so the load and store outputs can both be judged against the same size. The stimulus changes inputs only on falling edges and releases reset on a falling edge. It covers every size and offset pair and both extension modes with random data, including field values whose top bit is set and clear. Between edges it holds each input set steady for a whole cycle, so every registered output has exactly one sampled input set behind it.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;

    // Access size code; an access spans 2**code bytes.
    typedef enum logic [1:0] {
        SZ_BYTE   = 2'd0,
        SZ_HALF   = 2'd1,
        SZ_WORD   = 2'd2,
        SZ_DOUBLE = 2'd3
    } lane_size_e;

endpackage

// File: rtl/lsu_align_check.sv
module lsu_align_check
    import lsu_lane_pkg::*;
#(
    parameter int LANES = 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  lane_size_e       size_i,
    input  logic [OFF_W-1:0] off_i,
    output logic             misaligned_o
);
    logic [OFF_W:0] span_mask;

    always_comb begin
        span_mask    = (OFF_W+1)'(1) << size_i;
        span_mask    = span_mask - (OFF_W+1)'(1);
        misaligned_o = |({1'b0, off_i} & span_mask);
    end
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
    import lsu_lane_pkg::*;
#(
    parameter int LANES = 8,
    localparam int OFF_W = $clog2(LANES),
    localparam int DW    = LANES * 8
) (
    input  lane_size_e       size_i,
    input  logic [OFF_W-1:0] off_i,
    input  logic [DW-1:0]    src_i,
    output logic [DW-1:0]    wdata_o,
    output logic [LANES-1:0] be_o
);
    logic [OFF_W:0] span;

    always_comb span = (OFF_W+1)'(1) << size_i;

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic             hit;
        logic [OFF_W-1:0] src_idx;

        always_comb begin
            hit     = (j >= int'(off_i)) && (j < int'(off_i) + int'(span));
            src_idx = OFF_W'(j) - off_i;
            be_o[j] = hit;
            wdata_o[8*j +: 8] = hit ? src_i[8*src_idx +: 8] : 8'h00;
        end
    end
endmodule

// File: rtl/lsu_load_lane.sv
module lsu_load_lane
    import lsu_lane_pkg::*;
#(
    parameter int LANES = 8,
    localparam int OFF_W = $clog2(LANES),
    localparam int DW    = LANES * 8
) (
    input  lane_size_e       size_i,
    input  logic             unsigned_i,
    input  logic [OFF_W-1:0] off_i,
    input  logic [DW-1:0]    rword_i,
    output logic [DW-1:0]    value_o
);
    logic [DW-1:0]  aligned;
    logic [OFF_W:0] span;
    logic           fill_bit;

    always_comb begin
        aligned  = rword_i >> {off_i, 3'b000};
        span     = (OFF_W+1)'(1) << size_i;
        fill_bit = 1'b0;
        if (!unsigned_i && int'(span) < LANES)
            fill_bit = aligned[8*int'(span) - 1];
    end

    for (genvar j = 0; j < LANES; j++) begin : g_byte
        always_comb begin
            if (j < int'(span)) value_o[8*j +: 8] = aligned[8*j +: 8];
            else                value_o[8*j +: 8] = {8{fill_bit}};
        end
    end
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
    import lsu_lane_pkg::*;
#(
    parameter int LANES = 8,
    localparam int OFF_W = $clog2(LANES),
    localparam int DW    = LANES * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       acc_size_i,
    input  logic             load_unsigned_i,
    input  logic [OFF_W-1:0] addr_lo_i,
    input  logic [DW-1:0]    store_data_i,
    input  logic [DW-1:0]    read_word_i,
    output logic [DW-1:0]    wr_data_o,
    output logic [LANES-1:0] wr_be_o,
    output logic [DW-1:0]    load_value_o,
    output logic             misaligned_o
);
    typedef struct packed {
        logic [DW-1:0]    wdata;
        logic [LANES-1:0] be;
        logic [DW-1:0]    lval;
        logic             mis;
    } lane_out_t;

    lane_size_e       size_sel;
    logic             mis_c;
    logic [DW-1:0]    st_data_c;
    logic [LANES-1:0] st_be_c;
    logic [DW-1:0]    ld_val_c;
    lane_out_t        out_d, out_q;

    always_comb size_sel = lane_size_e'(acc_size_i);

    lsu_align_check #(.LANES(LANES)) u_align (
        .size_i       (size_sel),
        .off_i        (addr_lo_i),
        .misaligned_o (mis_c)
    );

    lsu_store_lane #(.LANES(LANES)) u_store (
        .size_i  (size_sel),
        .off_i   (addr_lo_i),
        .src_i   (store_data_i),
        .wdata_o (st_data_c),
        .be_o    (st_be_c)
    );

    lsu_load_lane #(.LANES(LANES)) u_load (
        .size_i     (size_sel),
        .unsigned_i (load_unsigned_i),
        .off_i      (addr_lo_i),
        .rword_i    (read_word_i),
        .value_o    (ld_val_c)
    );

    always_comb begin
        out_d     = '0;
        out_d.mis = mis_c;
        if (!mis_c) begin
            out_d.wdata = st_data_c;
            out_d.be    = st_be_c;
            out_d.lval  = ld_val_c;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign wr_data_o    = out_q.wdata;
    assign wr_be_o      = out_q.be;
    assign load_value_o = out_q.lval;
    assign misaligned_o = out_q.mis;

    // Aligned accesses enable exactly 2**size lanes.
    assert_be_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (misaligned_o || $countones(wr_be_o) == (1 << $past(acc_size_i))));

    // A misaligned access touches nothing.
    assert_mis_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        misaligned_o |-> (wr_be_o == '0 && wr_data_o == '0 && load_value_o == '0));

    // A doubleword at a nonzero offset is always flagged.
    assert_dword_offset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_size_i == 2'd3 && addr_lo_i != '0) |=> misaligned_o);

    // Unsigned byte loads leave the upper bits clear.
    assert_byte_zext_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_size_i == 2'd0 && load_unsigned_i) |=> (load_value_o[DW-1:8] == '0));

    // Signed word with a set top bit fills the upper half with ones.
    assert_word_sext_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_size_i == 2'd2 && !load_unsigned_i && addr_lo_i == '0 && read_word_i[31])
        |=> (&load_value_o[DW-1:32]));
endmodule

// File: tb/lsu_lane_unit_test.sv
module lsu_lane_unit_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  acc_size;
    logic        uns;
    logic [2:0]  off;
    logic [63:0] rs2, rword;
    logic [63:0] wr_data, load_value;
    logic [7:0]  wr_be;
    logic        mis;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    lsu_lane_unit uut (
        .clk(clk), .rst_n(rst_n), .acc_size_i(acc_size), .load_unsigned_i(uns),
        .addr_lo_i(off), .store_data_i(rs2), .read_word_i(rword),
        .wr_data_o(wr_data), .wr_be_o(wr_be), .load_value_o(load_value),
        .misaligned_o(mis)
    );

    // previously applied inputs
    logic [1:0]  p_sz;
    logic        p_uns;
    logic [2:0]  p_off;
    logic [63:0] p_rs2, p_rd;

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model(input logic [1:0] sz, input logic u, input logic [2:0] o,
                         input logic [63:0] s, input logic [63:0] r,
                         output logic [63:0] e_wd, output logic [7:0] e_be,
                         output logic [63:0] e_lv, output logic e_mis);
        int nb = 1 << sz;
        logic [63:0] v, keep;
        e_wd = 0; e_be = 0; e_lv = 0;
        e_mis = (int'(o) % nb) != 0;
        if (!e_mis) begin
            for (int i = 0; i < 8; i++) begin
                if (i >= int'(o) && i < int'(o) + nb) begin
                    e_be[i] = 1'b1;
                    e_wd[8*i +: 8] = s[8*(i - int'(o)) +: 8];
                end
            end
            v = r >> (8 * int'(o));
            if (nb < 8) begin
                keep = (64'd1 << (8 * nb)) - 64'd1;
                v = v & keep;
                if (!u && v[8*nb - 1]) v = v | ~keep;
            end
            e_lv = v;
        end
    endtask

    task automatic compare_prev();
        logic [63:0] e_wd, e_lv;
        logic [7:0]  e_be;
        logic        e_mis;
        string ltag;
        model(p_sz, p_uns, p_off, p_rs2, p_rd, e_wd, e_be, e_lv, e_mis);
        check("R8 misaligned", {63'd0, mis}, {63'd0, e_mis});
        if (e_mis) begin
            check("R9 be", {56'd0, wr_be}, {56'd0, e_be});
            check("R9 wdata", wr_data, e_wd);
            check("R9 load", load_value, e_lv);
        end else begin
            check("R2 be", {56'd0, wr_be}, {56'd0, e_be});
            check("R3 wdata", wr_data, e_wd);
            case (p_sz)
                2'd0: ltag = "R7 byte load";
                2'd1: ltag = "R6 half load";
                2'd2: ltag = "R5 word load";
                default: ltag = "R4 dword load";
            endcase
            check(ltag, load_value, e_lv);
        end
    endtask

    task automatic apply(logic [1:0] sz, logic u, logic [2:0] o, logic [63:0] s, logic [63:0] r);
        acc_size = sz; uns = u; off = o; rs2 = s; rword = r;
        p_sz = sz; p_uns = u; p_off = o; p_rs2 = s; p_rd = r;
        @(negedge clk);
        compare_prev();
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] hold_wd, hold_lv;
        logic [7:0]  hold_be;
        rst_n = 1'b0;
        acc_size = 2'd0; uns = 1'b0; off = 3'd1;
        rs2 = 64'hFFFF_FFFF_FFFF_FFFF; rword = 64'hFFFF_FFFF_FFFF_FFFF;
        repeat (3) @(negedge clk);
        // R1: outputs held at zero during reset despite active inputs
        check("R1 reset wdata", wr_data, 64'd0);
        check("R1 reset be", {56'd0, wr_be}, 64'd0);
        check("R1 reset load", load_value, 64'd0);
        check("R1 reset mis", {63'd0, mis}, 64'd0);
        rst_n = 1'b1;
        // R1: before the first edge after release, still zero
        #1 check("R1 after release", load_value, 64'd0);
        @(negedge clk);

        // directed corners
        apply(2'd3, 1'b0, 3'd0, 64'h0123_4567_89AB_CDEF, 64'hF0E1_D2C3_B4A5_9687); // R4
        apply(2'd3, 1'b1, 3'd0, 64'h1, 64'h8000_0000_0000_0001);                   // R4 unsigned no effect
        apply(2'd2, 1'b0, 3'd4, 64'hAAAA_BBBB_CCCC_DDDD, 64'h8765_4321_0000_0000); // R5 sign
        apply(2'd2, 1'b1, 3'd4, 64'hAAAA_BBBB_CCCC_DDDD, 64'h8765_4321_0000_0000); // R5 zero
        apply(2'd2, 1'b0, 3'd0, 64'h0, 64'h0000_0000_7FFF_FFFF);                   // R5 positive
        apply(2'd1, 1'b0, 3'd6, 64'h0000_0000_0000_BEEF, 64'h9ABC_0000_0000_0000); // R6 sign
        apply(2'd1, 1'b1, 3'd6, 64'h0000_0000_0000_BEEF, 64'h9ABC_0000_0000_0000); // R6 zero
        apply(2'd0, 1'b0, 3'd7, 64'h0000_0000_0000_0080, 64'h8000_0000_0000_0000); // R7 sign
        apply(2'd0, 1'b1, 3'd7, 64'h0000_0000_0000_0080, 64'h8000_0000_0000_0000); // R7 zero
        apply(2'd0, 1'b0, 3'd3, 64'hFFFF_FFFF_FFFF_FF5A, 64'h0000_0000_7F00_0000); // R2/R3
        apply(2'd1, 1'b0, 3'd3, 64'h1234, 64'hFFFF);                               // R8/R9 odd half
        apply(2'd2, 1'b0, 3'd2, 64'h1234, 64'hFFFF);                               // R8/R9 word at 2
        apply(2'd3, 1'b0, 3'd4, 64'h1234, 64'hFFFF);                               // R8/R9 dword at 4

        // R10: outputs hold between edges while new inputs are presented
        hold_wd = wr_data; hold_be = wr_be; hold_lv = load_value;
        acc_size = 2'd0; uns = 1'b1; off = 3'd0; rs2 = 64'h55; rword = 64'hAA;
        #1;
        check("R10 hold wdata", wr_data, hold_wd);
        check("R10 hold be", {56'd0, wr_be}, {56'd0, hold_be});
        check("R10 hold load", load_value, hold_lv);
        apply(2'd0, 1'b1, 3'd0, 64'h55, 64'hAA);

        // every size/offset/sign combination with random data
        for (int sz = 0; sz < 4; sz++)
            for (int o = 0; o < 8; o++)
                for (int u = 0; u < 2; u++)
                    apply(2'(sz), 1'(u), 3'(o), {$urandom, $urandom}, {$urandom, $urandom});

        for (int k = 0; k < 3000; k++)
            apply(2'($urandom), 1'($urandom), 3'($urandom), {$urandom, $urandom}, {$urandom, $urandom});

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule